// File: doc/BRIEF.md
# Three-Axis Sample Freshness Status Flags

This block tracks whether the three axis samples currently held in a sensor's output registers are fresh, and whether any of them was replaced before software fetched it. It watches two strobe vectors: one pulses when the data path writes a new sample for an axis, the other pulses when the register read port returns that axis's high data byte. From these it keeps a data-ready flag and an overwrite flag for each axis, plus a combined data-ready and a combined overwrite flag for the whole set. All eight flags are packed into one read-only status byte.

Flags clear only as a side effect of reads. There is no separate acknowledge. A per-axis flag clears when that axis's high byte is read. The combined flags clear only after all three high bytes have been read since the last time a new sample arrived on any axis. Samples are 12-bit two's complement values, stored as a high byte plus the upper nibble of a low byte. Only reads of the high byte matter here.

Top module: `sflag_status`

## Requirements
- R1: The status byte carries, from bit 7 down to bit 0: combined overwrite, Z overwrite, Y overwrite, X overwrite, combined ready, Z ready, Y ready, X ready. In both strobe vectors bit 0 is X, bit 1 is Y and bit 2 is Z.
- R2: A new-sample strobe on an axis sets that axis's ready flag on the next cycle.
- R3: A high-byte read strobe on an axis clears that axis's ready flag on the next cycle. A read of an axis whose flags are already clear changes nothing.
- R4: A new-sample strobe on an axis whose ready flag is still set also sets that axis's overwrite flag on the next cycle.
- R5: A high-byte read strobe on an axis clears that axis's overwrite flag on the next cycle.
- R6: A new-sample strobe on any axis sets the combined ready flag on the next cycle.
- R7: The combined ready flag clears only in the cycle after the high bytes of all three axes have been read since the most recent new sample on any axis. The reads may come in any order, over several cycles or in one cycle. A new sample on any axis discards the reads counted so far.
- R8: The combined overwrite flag sets whenever any per-axis overwrite event occurs. It clears under the same all-three-read condition as the combined ready flag.
- R9: When a new-sample strobe and a high-byte read strobe of the same axis occur in the same cycle, the set wins: the ready flag ends up set, and the read does not count toward clearing the combined flags.
- R10: A synchronous active-high reset clears every flag and all read tracking, so the status byte reads 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_new | input | 3 | Per-axis new-sample strobe (bit0 X, bit1 Y, bit2 Z) |
| hi_rd | input | 3 | Per-axis high-byte read strobe (bit0 X, bit1 Y, bit2 Z) |
| status | output | 8 | Packed status byte |

## Verification
The assertions check the one-cycle flag behaviour on every cycle:
- each per-axis ready and overwrite flag sets after a strobe and clears after a read;
- the combined flags set on any new sample or any overwrite event;
- the combined ready flag holds while no high byte is read;
- reset clears the byte.

Some behaviour depends on a history of reads that a single-cycle property cannot express. Examples are the all-three-read condition for clearing the combined flags, the loss of partial read progress when a sample arrives mid-sequence, and same-cycle set-versus-read collisions. The bench's behavioural model shows these through its scenarios, comparing the whole byte every clock.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int NUM_AXES = 3;

    // Packed layout: the field order gives the bit order of the status byte.
    typedef struct packed {
        logic                grp_ow;
        logic [NUM_AXES-1:0] ax_ow;
        logic                grp_dr;
        logic [NUM_AXES-1:0] ax_dr;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    // True when every axis has been read, counting reads made this cycle.
    function automatic logic all_axes_read(input logic [NUM_AXES-1:0] seen,
                                           input logic [NUM_AXES-1:0] rd);
        return &(seen | rd);
    endfunction

endpackage

// File: rtl/sflag_axis.sv
module sflag_axis (
    input  logic clk,
    input  logic rst,
    input  logic new_smp,
    input  logic hi_read,
    output logic rdy,
    output logic ovw,
    output logic ovw_evt
);

    // A sample lands while the previous one is still unread.
    assign ovw_evt = new_smp & rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0;
            ovw <= 1'b0;
        end else begin
            if (new_smp)      rdy <= 1'b1;
            else if (hi_read) rdy <= 1'b0;

            if (ovw_evt)      ovw <= 1'b1;
            else if (hi_read) ovw <= 1'b0;
        end
    end

endmodule

// File: rtl/sflag_group.sv
module sflag_group
    import sflag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_AXES-1:0] new_vec,
    input  logic [NUM_AXES-1:0] rd_vec,
    input  logic [NUM_AXES-1:0] ovw_evt_vec,
    output logic                grp_rdy,
    output logic                grp_ovw
);

    logic [NUM_AXES-1:0] seen_q;
    logic                any_new;
    logic                any_ovw;
    logic                set_done;

    assign any_new  = |new_vec;
    assign any_ovw  = |ovw_evt_vec;
    assign set_done = all_axes_read(seen_q, rd_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            grp_rdy <= 1'b0;
            grp_ovw <= 1'b0;
        end else begin
            // Any new sample restarts the read sequence.
            if (any_new || set_done) seen_q <= '0;
            else                     seen_q <= seen_q | rd_vec;

            if (any_new)       grp_rdy <= 1'b1;
            else if (set_done) grp_rdy <= 1'b0;

            if (any_ovw)       grp_ovw <= 1'b1;
            else if (set_done) grp_ovw <= 1'b0;
        end
    end

endmodule

// File: rtl/sflag_status.sv
module sflag_status
    import sflag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_AXES-1:0] smp_new,
    input  logic [NUM_AXES-1:0] hi_rd,
    output logic [STATUS_W-1:0] status
);

    logic [NUM_AXES-1:0] ax_rdy;
    logic [NUM_AXES-1:0] ax_ovw;
    logic [NUM_AXES-1:0] ax_evt;
    logic                grp_rdy;
    logic                grp_ovw;
    status_t             st;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        sflag_axis u_axis (
            .clk     (clk),
            .rst     (rst),
            .new_smp (smp_new[a]),
            .hi_read (hi_rd[a]),
            .rdy     (ax_rdy[a]),
            .ovw     (ax_ovw[a]),
            .ovw_evt (ax_evt[a])
        );
    end

    sflag_group u_group (
        .clk         (clk),
        .rst         (rst),
        .new_vec     (smp_new),
        .rd_vec      (hi_rd),
        .ovw_evt_vec (ax_evt),
        .grp_rdy     (grp_rdy),
        .grp_ovw     (grp_ovw)
    );

    always_comb begin
        st.grp_ow = grp_ovw;
        st.ax_ow  = ax_ovw;
        st.grp_dr = grp_rdy;
        st.ax_dr  = ax_rdy;
    end

    assign status = st;

endmodule

// File: rtl/sflag_status_chk.sv
module sflag_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] smp_new,
    input logic [2:0] hi_rd,
    input logic [7:0] status
);

    // R10: reset empties the byte
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> status == 8'h00);

    for (genvar i = 0; i < 3; i++) begin : g_ax
        // R2
        a_r2_ready_set: assert property (@(posedge clk) disable iff (rst)
            smp_new[i] |=> status[i]);
        // R3
        a_r3_ready_clear: assert property (@(posedge clk) disable iff (rst)
            (hi_rd[i] && !smp_new[i]) |=> !status[i]);
        // R4
        a_r4_overwrite_set: assert property (@(posedge clk) disable iff (rst)
            (smp_new[i] && status[i]) |=> status[4+i]);
        // R5
        a_r5_overwrite_clear: assert property (@(posedge clk) disable iff (rst)
            (hi_rd[i] && !smp_new[i]) |=> !status[4+i]);
    end

    // R6
    a_r6_group_ready_set: assert property (@(posedge clk) disable iff (rst)
        (|smp_new) |=> status[3]);

    // R7: without any high-byte read the combined ready flag cannot drop
    a_r7_group_ready_hold: assert property (@(posedge clk) disable iff (rst)
        (status[3] && hi_rd == 3'b000) |=> status[3]);

    // R8
    a_r8_group_overwrite_set: assert property (@(posedge clk) disable iff (rst)
        (|(smp_new & status[2:0])) |=> status[7]);

endmodule

bind sflag_status sflag_status_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_new (smp_new),
    .hi_rd   (hi_rd),
    .status  (status)
);

// File: tb/sflag_status_test.sv
`timescale 1ns/1ps
module sflag_status_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] smp_new = 3'b000;
    logic [2:0] hi_rd = 3'b000;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;

    // Behavioural reference state
    bit m_dr[3];
    bit m_ow[3];
    bit m_gdr;
    bit m_gow;
    int m_reads;  // bitmask of axes read since the last new sample

    always #10 clk = ~clk;

    sflag_status uut (
        .clk     (clk),
        .rst     (rst),
        .smp_new (smp_new),
        .hi_rd   (hi_rd),
        .status  (status)
    );

    function automatic logic [7:0] model_byte();
        logic [7:0] b;
        b = 8'h00;
        for (int k = 0; k < 3; k++) begin
            b[k]     = m_dr[k];
            b[4 + k] = m_ow[k];
        end
        b[3] = m_gdr;
        b[7] = m_gow;
        return b;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 3; k++) begin
            m_dr[k] = 0;
            m_ow[k] = 0;
        end
        m_gdr = 0;
        m_gow = 0;
        m_reads = 0;
    endtask

    task automatic model_step(input logic [2:0] n, input logic [2:0] r);
        bit any_new;
        bit any_ow;
        bit done;
        any_new = (n != 0);
        any_ow = 0;
        done = ((m_reads | int'(r)) == 7);
        for (int k = 0; k < 3; k++) begin
            if (n[k] && m_dr[k]) any_ow = 1;
        end
        for (int k = 0; k < 3; k++) begin
            if (n[k] && m_dr[k]) m_ow[k] = 1;
            else if (r[k])       m_ow[k] = 0;
            if (n[k])            m_dr[k] = 1;
            else if (r[k])       m_dr[k] = 0;
        end
        if (any_new)   m_gdr = 1;
        else if (done) m_gdr = 0;
        if (any_ow)    m_gow = 1;
        else if (done) m_gow = 0;
        if (any_new || done) m_reads = 0;
        else                 m_reads = m_reads | int'(r);
    endtask

    task automatic compare(input string tag);
        logic [7:0] exp_b;
        exp_b = model_byte();
        checks++;
        if (status !== exp_b) begin
            failures++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, status, exp_b);
        end
    endtask

    // Called at a negedge: drive, let one edge pass, compare, return at negedge.
    task automatic step(input string tag, input logic [2:0] n, input logic [2:0] r);
        smp_new = n;
        hi_rd = r;
        model_step(n, r);
        @(posedge clk);
        #2;
        compare(tag);
        @(negedge clk);
        smp_new = 3'b000;
        hi_rd = 3'b000;
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        model_clear();
        @(posedge clk);
        #2;
        compare(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset("R10 reset state");

        // R3: reads with no data leave everything clear
        step("R3 idle read", 3'b000, 3'b111);

        // R2, R6, R1: single X sample -> 0x09
        step("R2 R6 R1 X new", 3'b001, 3'b000);
        // R3: X read clears X ready, combined holds
        step("R3 X read", 3'b000, 3'b001);
        step("R7 Z read", 3'b000, 3'b100);
        step("R7 Y read clears group", 3'b000, 3'b010);

        // R4: Y overwritten -> 0xAA
        step("R4 Y new", 3'b010, 3'b000);
        step("R4 R8 Y overwrite", 3'b010, 3'b000);
        step("R5 Y read", 3'b000, 3'b010);
        step("R7 X read", 3'b000, 3'b001);
        step("R8 Z read clears group", 3'b000, 3'b100);

        // All axes, twice, then one-cycle read of all three
        step("R2 R1 all new", 3'b111, 3'b000);
        step("R4 R8 all overwrite", 3'b111, 3'b000);
        step("R5 R7 read all at once", 3'b000, 3'b111);

        // R7: a new sample discards partial read progress
        step("R2 all new", 3'b111, 3'b000);
        step("R7 X read", 3'b000, 3'b001);
        step("R7 Y read", 3'b000, 3'b010);
        step("R7 X new restarts", 3'b001, 3'b000);
        step("R7 Z read keeps group", 3'b000, 3'b100);
        step("R7 X read keeps group", 3'b000, 3'b001);
        step("R7 Y read clears group", 3'b000, 3'b010);

        // R9: set wins over a same-cycle read of the same axis
        step("R9 Z new", 3'b100, 3'b000);
        step("R9 Z new and read", 3'b100, 3'b100);
        step("R9 X Y read", 3'b000, 3'b011);
        step("R9 Z read clears", 3'b000, 3'b100);

        // R9: read of a different axis in the collision cycle
        step("R9 X new Y read", 3'b001, 3'b010);
        step("R9 Y Z read keeps", 3'b000, 3'b110);
        step("R9 X read clears", 3'b000, 3'b001);

        // R10: mid-run reset
        step("R2 set before reset", 3'b011, 3'b000);
        step("R4 overwrite before reset", 3'b011, 3'b000);
        do_reset("R10 mid-run reset");
        step("R10 idle after reset", 3'b000, 3'b000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule